// File: doc/BRIEF.md
# Bridge enable and initialization gate

This block is the control and gating logic for the host side of a bus bridge. It owns two control bits that reset to zero: a global enable bit and an initialization-complete bit. A strap input, sampled only while reset is held, selects host mode or device mode. Software reaches the bit registers and a small set of configuration registers through a simple register port with an address, a write strobe, write data and registered read data.

The two bits open the bridge in stages. While the enable bit is clear, only the control register can be reached: other writes are dropped and other reads return zero. While the initialization-complete bit is clear, outbound transactions are refused at once rather than queued, and inbound accesses are answered with a retry. In host mode the bus grant also stays parked on the bridge. Once initialization completes, inbound accesses are accepted. In host mode the grant then rotates round-robin among the external request lines and the bridge's own request.

Top module: `bridge_init_gate`

## Requirements
- R1: A synchronous active-high reset clears both bits, all configuration registers and all outputs. The mode strap (1 = host) is captured only on clock edges while reset is high; later strap changes have no effect.
- R2: While the enable bit is 0, a write to any address other than 0 changes nothing, and a read of any address other than 0 returns 0.
- R3: Address 0 is always accessible. Bit 0 is the enable bit (read/write) and bit 1 returns the captured mode (1 = host, read-only). All other bits read 0.
- R4: Address 1 bit 0 holds the initialization-complete bit. It changes on a write only while the enable bit is already 1. Other bits read 0.
- R5: Addresses 2 to 9 are configuration registers, writable and readable whenever the enable bit is 1, even before initialization completes. Addresses 2 to 5 keep only their low 16 bits; addresses 6 to 9 keep the full data width.
- R6: An outbound request (`ob_req`) raises `ob_launch` in the next cycle when both bits are 1. Otherwise it raises `ob_err` in the next cycle and is not remembered.
- R7: In host mode, while the initialization-complete bit is 0, `self_gnt` is 1 and `ext_gnt` is 0 from the cycle after reset onward, whatever the requests.
- R8: An inbound request (`ib_req`) gets `ib_retry` in the next cycle while the initialization-complete bit is 0, and `ib_ack` in the next cycle once it is 1.
- R9: In host mode with initialization complete, the grant is registered and round-robin over requesters 0..NUM_EXT-1 (`ext_req`) and requester NUM_EXT (the bridge, `ob_req`). After granting k, the search starts at k+1 and wraps, starting at 0 after reset. No request gives no grant. In device mode both grant outputs stay 0.
- R10: `reg_rdata` shows the register addressed in the previous cycle, as it stood before any write in that cycle. Unmapped addresses (10 to 15) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strap | input | 1 | Mode strap, 1 = host, captured during reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| ob_req | input | 1 | Outbound transaction request, also the bridge's arbitration request |
| ob_launch | output | 1 | Outbound transaction launched |
| ob_err | output | 1 | Outbound transaction refused |
| ib_req | input | 1 | Inbound access from an external master |
| ib_ack | output | 1 | Inbound access accepted |
| ib_retry | output | 1 | Inbound access answered with retry |
| ext_req | input | NUM_EXT | External bus requests |
| ext_gnt | output | NUM_EXT | External bus grants |
| self_gnt | output | 1 | Bus granted to the bridge |

## Verification
The assertions assume that reset is held for at least one clock edge before it is released and that the strap is steady during that edge. They also assume that every input is driven to a known level in each cycle, so the request and address checks never see unknown values. The stimulus drives all inputs away from the active edge, holds reset for three edges in each mode, and draws each input from a small legal range (addresses 0 to 11, single-bit requests). It toggles the strap only after reset has been released.

// File: rtl/big_pkg.sv
package big_pkg;
  // register map width and fixed offsets decoded by the register unit
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_INIT = 4'd1;
  localparam logic [ADDR_W-1:0] A_CFG0 = 4'd2;
  // configuration register bank: first NARROW_CFG entries are NARROW_W wide
  localparam int NUM_CFG    = 8;
  localparam int NARROW_CFG = 4;
  localparam int NARROW_W   = 16;
endpackage

// File: rtl/big_regs.sv
module big_regs
  import big_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_strap,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              host_q,
  output logic              en_q,
  output logic              init_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int CIDX_W = $clog2(NUM_CFG);

  logic [DATA_W-1:0] cfg_arr [NUM_CFG];
  logic [ADDR_W-1:0] cfg_off;
  logic              cfg_hit;
  logic [DATA_W-1:0] rd_mux;

  // mode strap is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) host_q <= host_strap;
  end

  // enable bit: its register is reachable in every state
  always_ff @(posedge clk) begin
    if (rst)                         en_q <= 1'b0;
    else if (wr && addr == A_CTRL)   en_q <= wdata[0];
  end

  // init-done bit: write only takes effect once enabled
  always_ff @(posedge clk) begin
    if (rst)                                 init_q <= 1'b0;
    else if (wr && en_q && addr == A_INIT)   init_q <= wdata[0];
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam int FW = (g < NARROW_CFG) ? NARROW_W : DATA_W;
    localparam logic [DATA_W-1:0] FMASK = {DATA_W{1'b1}} >> (DATA_W - FW);
    localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(int'(A_CFG0) + g);
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)                               val_q <= '0;
      else if (wr && en_q && addr == FADDR)  val_q <= wdata & FMASK;
    end
    assign cfg_arr[g] = val_q;
  end

  assign cfg_off = addr - A_CFG0;
  assign cfg_hit = (int'(addr) >= int'(A_CFG0)) &&
                   (int'(addr) < int'(A_CFG0) + NUM_CFG);

  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL) begin
      rd_mux[0] = en_q;
      rd_mux[1] = host_q;
    end else if (!en_q) begin
      rd_mux = '0;
    end else if (addr == A_INIT) begin
      rd_mux[0] = init_q;
    end else if (cfg_hit) begin
      rd_mux = cfg_arr[cfg_off[CIDX_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/big_gate.sv
module big_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic init,
  input  logic ob_req,
  input  logic ib_req,
  output logic ob_launch,
  output logic ob_err,
  output logic ib_ack,
  output logic ib_retry
);
  logic ob_open;
  assign ob_open = en && init;

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_launch <= 1'b0;
      ob_err    <= 1'b0;
      ib_ack    <= 1'b0;
      ib_retry  <= 1'b0;
    end else begin
      ob_launch <= ob_req && ob_open;
      ob_err    <= ob_req && !ob_open;
      ib_ack    <= ib_req && init;
      ib_retry  <= ib_req && !init;
    end
  end
endmodule

// File: rtl/big_rr_arb.sv
module big_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         lock,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] pick;
  logic [N-1:0]  pick_vec;
  logic          found;
  int            idx;

  // rotating-priority search starting just after the last winner
  always_comb begin
    found    = 1'b0;
    pick     = ptr_q;
    pick_vec = '0;
    idx      = 0;
    for (int off = 1; off <= N; off++) begin
      idx = int'(ptr_q) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found         = 1'b1;
        pick          = PW'(idx);
        pick_vec[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt   <= '0;
      ptr_q <= PW'(N - 1);
    end else if (!active) begin
      gnt <= '0;
    end else if (lock) begin
      gnt        <= '0;
      gnt[N-1]   <= 1'b1;
    end else begin
      gnt <= pick_vec;
      if (found) ptr_q <= pick;
    end
  end
endmodule

// File: rtl/bridge_init_gate.sv
module bridge_init_gate
  import big_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_strap,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               ob_req,
  output logic               ob_launch,
  output logic               ob_err,
  input  logic               ib_req,
  output logic               ib_ack,
  output logic               ib_retry,
  input  logic [NUM_EXT-1:0] ext_req,
  output logic [NUM_EXT-1:0] ext_gnt,
  output logic               self_gnt
);
  localparam int NREQ = NUM_EXT + 1;

  logic            host_q;
  logic            en_q;
  logic            init_q;
  logic [NREQ-1:0] arb_req;
  logic [NREQ-1:0] arb_gnt;

  big_regs #(.DATA_W(DATA_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .host_strap (host_strap),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .host_q     (host_q),
    .en_q       (en_q),
    .init_q     (init_q),
    .rdata      (reg_rdata)
  );

  big_gate gate_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .init      (init_q),
    .ob_req    (ob_req),
    .ib_req    (ib_req),
    .ob_launch (ob_launch),
    .ob_err    (ob_err),
    .ib_ack    (ib_ack),
    .ib_retry  (ib_retry)
  );

  // bridge is the highest-index requester
  assign arb_req = {ob_req, ext_req};

  big_rr_arb #(.N(NREQ)) arb_i (
    .clk    (clk),
    .rst    (rst),
    .active (host_q),
    .lock   (!init_q),
    .req    (arb_req),
    .gnt    (arb_gnt)
  );

  assign ext_gnt  = arb_gnt[NUM_EXT-1:0];
  assign self_gnt = arb_gnt[NUM_EXT];
endmodule

// File: rtl/big_chk.sv
module big_chk
  import big_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_EXT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               host_q,
  input logic               en_q,
  input logic               init_q,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               ob_req,
  input logic               ob_launch,
  input logic               ob_err,
  input logic               ib_req,
  input logic               ib_ack,
  input logic               ib_retry,
  input logic [NUM_EXT-1:0] ext_req,
  input logic [NUM_EXT-1:0] ext_gnt,
  input logic               self_gnt
);
  // R2
  rd_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && reg_addr != A_CTRL) |=> (reg_rdata == '0));

  // R4
  init_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(init_q));

  // R6
  ob_resp_chk: assert property (@(posedge clk) disable iff (rst)
    ob_req |=> (ob_launch != ob_err));

  // R6
  ob_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ob_launch |-> $past(en_q && init_q));

  // R7
  host_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (host_q && !init_q) |=> (self_gnt && ext_gnt == '0));

  // R8
  ib_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (ib_req && !init_q) |=> (ib_retry && !ib_ack));

  // R8
  ib_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ib_ack |-> $past(ib_req && init_q));

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({self_gnt, ext_gnt}));

  // R9
  gnt_req_chk: assert property (@(posedge clk) disable iff (rst)
    (host_q && $past(init_q)) |-> ((ext_gnt & ~$past(ext_req)) == '0));

  // R9
  dev_nognt_chk: assert property (@(posedge clk) disable iff (rst)
    !host_q |-> (ext_gnt == '0 && !self_gnt));
endmodule

bind bridge_init_gate big_chk #(.DATA_W(DATA_W), .NUM_EXT(NUM_EXT)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .host_q    (host_q),
  .en_q      (en_q),
  .init_q    (init_q),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .ob_req    (ob_req),
  .ob_launch (ob_launch),
  .ob_err    (ob_err),
  .ib_req    (ib_req),
  .ib_ack    (ib_ack),
  .ib_retry  (ib_retry),
  .ext_req   (ext_req),
  .ext_gnt   (ext_gnt),
  .self_gnt  (self_gnt)
);

// File: tb/bridge_init_gate_tb_top.sv
module bridge_init_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int NUM_EXT    = 4;
  localparam int NREQ       = NUM_EXT + 1;
  localparam int N_RAND     = 1500;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               host_strap = 1'b0;
  logic [3:0]         reg_addr = '0;
  logic               reg_wr = 1'b0;
  logic [DATA_W-1:0]  reg_wdata = '0;
  logic [DATA_W-1:0]  reg_rdata;
  logic               ob_req = 1'b0;
  logic               ob_launch, ob_err;
  logic               ib_req = 1'b0;
  logic               ib_ack, ib_retry;
  logic [NUM_EXT-1:0] ext_req = '0;
  logic [NUM_EXT-1:0] ext_gnt;
  logic               self_gnt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model state
  bit              m_host, m_en, m_init;
  logic [DATA_W-1:0] m_cfg [8];
  int              m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_init_gate #(.DATA_W(DATA_W), .NUM_EXT(NUM_EXT)) dut_i (
    .clk(clk), .rst(rst), .host_strap(host_strap),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ob_req(ob_req), .ob_launch(ob_launch), .ob_err(ob_err),
    .ib_req(ib_req), .ib_ack(ib_ack), .ib_retry(ib_retry),
    .ext_req(ext_req), .ext_gnt(ext_gnt), .self_gnt(self_gnt)
  );

  task automatic check(string tag, string what, logic [DATA_W-1:0] got,
                       logic [DATA_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] cfg_mask(int i);
    return (i < 4) ? DATA_W'(32'h0000_FFFF) : {DATA_W{1'b1}};
  endfunction

  function automatic logic [DATA_W-1:0] model_read(int a);
    logic [DATA_W-1:0] v = '0;
    if (a == 0) begin v[0] = m_en; v[1] = m_host; end
    else if (!m_en) v = '0;
    else if (a == 1) v[0] = m_init;
    else if (a >= 2 && a <= 9) v = m_cfg[a-2];
    return v;
  endfunction

  function automatic string rd_tag(int a);
    if (a == 0) return "R3";
    if (!m_en) return "R2";
    if (a == 1) return "R4";
    if (a <= 9) return "R5";
    return "R10";
  endfunction

  task automatic do_reset(bit strap);
    rst = 1'b1;
    host_strap = strap;
    reg_wr = 1'b0; ob_req = 1'b0; ib_req = 1'b0; ext_req = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    host_strap = ~strap;   // R1: changes after reset must be ignored
    m_host = strap; m_en = 0; m_init = 0; m_ptr = NREQ - 1;
    for (int i = 0; i < 8; i++) m_cfg[i] = '0;
    // R1 reset state of every output
    check("R1", "rdata after reset", reg_rdata, '0);
    check("R1", "outputs after reset",
          DATA_W'({ob_launch, ob_err, ib_ack, ib_retry, ext_gnt, self_gnt}), '0);
  endtask

  task automatic step(int a, bit wr, logic [DATA_W-1:0] wd, bit obr, bit ibr,
                      logic [NUM_EXT-1:0] er);
    logic [DATA_W-1:0] e_rd;
    logic [NREQ-1:0]   e_gnt, rq;
    bit                found;
    string             t;
    @(negedge clk);
    reg_addr = 4'(a); reg_wr = wr; reg_wdata = wd;
    ob_req = obr; ib_req = ibr; ext_req = er;
    // expected values from the state before this edge
    e_rd = model_read(a);
    t = rd_tag(a);
    e_gnt = '0;
    rq = {obr, er};
    if (m_host && !m_init) e_gnt[NREQ-1] = 1'b1;
    else if (m_host) begin
      found = 0;
      for (int off = 1; off <= NREQ; off++) begin
        int ix;
        ix = (m_ptr + off) % NREQ;
        if (!found && rq[ix]) begin found = 1; e_gnt[ix] = 1'b1; m_ptr = ix; end
      end
    end
    @(posedge clk);
    #1;
    check(t, "rdata", reg_rdata, e_rd);
    check("R6", "ob_launch", DATA_W'(ob_launch), DATA_W'(obr && m_en && m_init));
    check("R6", "ob_err", DATA_W'(ob_err), DATA_W'(obr && !(m_en && m_init)));
    check("R8", "ib_ack", DATA_W'(ib_ack), DATA_W'(ibr && m_init));
    check("R8", "ib_retry", DATA_W'(ib_retry), DATA_W'(ibr && !m_init));
    check((m_host && !m_init) ? "R7" : "R9", "grant",
          DATA_W'({self_gnt, ext_gnt}), DATA_W'(e_gnt));
    // apply write to model
    if (wr) begin
      if (a == 0) m_en = wd[0];
      else if (m_en && a == 1) m_init = wd[0];
      else if (m_en && a >= 2 && a <= 9) m_cfg[a-2] = wd & cfg_mask(a-2);
    end
  endtask

  task automatic rand_phase();
    for (int n = 0; n < N_RAND; n++) begin
      int a;
      logic [DATA_W-1:0] wd;
      a  = int'($urandom % 12);
      wd = $urandom;
      if (a == 0) wd[0] = ($urandom % 8) != 0;
      if (a == 1) wd[0] = ($urandom % 4) != 0;
      step(a, ($urandom % 2) == 1, wd, ($urandom % 2) == 1,
           ($urandom % 2) == 1, NUM_EXT'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // ---- host mode ----
    do_reset(1'b1);
    step(0, 0, '0, 0, 0, '0);                       // R3 mode bit reads 1
    step(2, 1, 32'hDEAD_BEEF, 1, 1, 4'hF);          // R2 write dropped, R6 err, R7 lock
    step(2, 0, '0, 0, 0, 4'hF);                     // R2 read 0
    step(1, 1, 32'h1, 0, 0, '0);                    // R4 init write ignored
    step(1, 0, '0, 0, 0, '0);
    step(0, 1, 32'h1, 0, 0, '0);                    // enable
    step(1, 0, '0, 0, 0, '0);                       // R4 still 0
    step(2, 1, 32'h1234_5678, 1, 1, '0);            // R5 narrow write, R6 err
    step(7, 1, 32'hCAFE_F00D, 0, 0, 4'h3);          // R5 wide write
    step(2, 0, '0, 0, 0, '0);                       // R5 masked readback
    step(7, 0, '0, 0, 0, '0);
    step(12, 0, '0, 0, 0, '0);                      // R10 unmapped
    step(1, 1, 32'h1, 0, 0, '0);                    // init done
    step(0, 0, '0, 1, 1, 4'hF);                     // R9 first grant index 0
    step(0, 0, '0, 1, 0, 4'hF);                     // R9 index 1
    step(0, 0, '0, 1, 0, 4'h0);                     // R9 bridge
    step(0, 0, '0, 0, 0, 4'h0);                     // R9 no request
    step(0, 0, '0, 0, 0, 4'h1);                     // R9 wrap to 0
    rand_phase();
    // ---- device mode ----
    do_reset(1'b0);
    step(0, 1, 32'h1, 0, 1, 4'hF);                  // R8 retry, R9 no grant
    step(0, 0, '0, 1, 1, 4'hF);                     // R3 mode bit 0
    step(1, 1, 32'h1, 0, 1, '0);
    step(9, 1, 32'hFFFF_FFFF, 1, 1, '0);            // R8 ack, R6 launch
    step(9, 0, '0, 0, 0, '0);
    step(0, 1, 32'h0, 1, 0, '0);                    // disable
    step(9, 1, 32'h0, 1, 0, '0);                    // R2 dropped, R6 err
    step(9, 0, '0, 0, 0, '0);
    rand_phase();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule